// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block watches over a twisted-pair link on behalf of the transceiver around it. When the transmit path is quiet, it sends an idle link pulse request to the line driver at a fixed interval. It tracks received link pulses, which arrive already qualified and tagged with their polarity, and it tracks receive carrier. From these it keeps a two-state link verdict: pass or fail. The verdict drives an enable that gates transmission, reception and collision detection. It also drives an active-low link-good status and a gated receive status.

Timing is counted in ticks of a clock-enable input, so the interval and timeout counts are parameters. A simulation can shorten them by orders of magnitude. Shaping and qualifying the analog pulse happen upstream.

A strap input turns the monitor off for partners that never send link pulses. The path then stays enabled and the status reads good. The idle pulses are still sent.

Top module: `lnk_integrity_mon`

## Requirements
- R1: While tx_active_i is low, lp_req_o rises once every PERIOD_TICKS ticks of tick_i and stays high for exactly PULSE_CYCLES clock cycles. The first pulse starts on the clock after the PERIOD_TICKS-th tick counted from reset or from the end of transmit activity.
- R2: A cycle with tx_active_i high restarts the interval count and ends any pulse in flight, so lp_req_o is low on the following cycle.
- R3: After reset the link verdict is fail: path_en_o is 0 and link_good_n_o is 1, unless strap_off_i is high.
- R4: Each cycle with rx_pulse_i or rx_carrier_i high restarts the loss timer. When LOSS_TICKS ticks pass with neither, a link in pass drops to fail on the next clock edge.
- R5: In fail, ENTRY_PULSES consecutive received pulses of the same polarity move the link to pass at the clock edge that samples the last one. Either polarity qualifies: rx_pulse_neg_i is 1 for negative and 0 for positive.
- R6: In fail, a pulse of the opposite polarity to the current run starts a new run of length 1. A pulse that arrives after the loss timer has already expired also starts a new run of length 1.
- R7: In fail, a cycle with rx_carrier_i high moves the link to pass at the next clock edge.
- R8: path_en_o is high exactly when the verdict is pass or strap_off_i is high, and link_good_n_o is always its complement.
- R9: With strap_off_i high, path_en_o is 1 and link_good_n_o is 0 whatever arrives, and idle pulse requests continue as in R1.
- R10: rcv_stat_o equals rx_carrier_i AND path_en_o, so receive status is suppressed while in link fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable, one cycle per tick |
| tx_active_i | input | 1 | Local transmitter is sending data |
| rx_carrier_i | input | 1 | Valid receive carrier present |
| rx_pulse_i | input | 1 | One-cycle event: qualified link pulse received |
| rx_pulse_neg_i | input | 1 | Polarity of the received pulse (1 = negative) |
| strap_off_i | input | 1 | Monitoring disabled by strap |
| lp_req_o | output | 1 | Idle link pulse request to the line driver |
| link_good_n_o | output | 1 | Link status, low when good |
| path_en_o | output | 1 | Enable for transmit, receive and collision functions |
| rcv_stat_o | output | 1 | Gated receive status |

## Verification
The hardest state to reach is a pulse run that has gone stale. Some same-polarity pulses arrive in fail, then the line stays silent long enough for the loss timer to expire, and then more pulses of the same polarity follow. If the block only counted runs, it would wrongly enter pass here. The stimulus sends three pulses, waits past the timeout, sends two more, and checks that the verdict is still fail. Three further pulses then complete a fresh run. A run broken by a polarity flip is driven the same way, using negative pulses to complete it.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_PASS = 1'b1
  } lnk_state_e;

  // Length of the same-polarity pulse run after one more pulse arrives.
  function automatic int unsigned lnk_run_step(int unsigned run_len,
                                               logic same_pol,
                                               logic stale);
    if (run_len == 0 || !same_pol || stale) return 1;
    return run_len + 1;
  endfunction

endpackage

// File: rtl/lnk_pulse_gen.sv
module lnk_pulse_gen #(
  parameter int PERIOD_TICKS = 16000,
  parameter int PULSE_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic tx_active_i,
  output logic fire_o,
  output logic lp_req_o
);
  localparam int PER_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int WID_W = $clog2(PULSE_CYCLES + 1);

  logic [PER_W-1:0] per_q;
  logic [WID_W-1:0] wid_q;

  assign fire_o = tick_i && !tx_active_i && (per_q == PER_W'(PERIOD_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      wid_q <= '0;
    end else if (tx_active_i) begin
      per_q <= '0;
      wid_q <= '0;
    end else begin
      if (tick_i) per_q <= fire_o ? '0 : per_q + 1'b1;
      if (fire_o) wid_q <= WID_W'(PULSE_CYCLES);
      else if (wid_q != '0) wid_q <= wid_q - 1'b1;
    end
  end

  assign lp_req_o = (wid_q != '0);

endmodule

// File: rtl/lnk_loss_timer.sv
module lnk_loss_timer #(
  parameter int LOSS_TICKS = 65000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic restart_i,
  output logic expired_o
);
  localparam int LOSS_W = $clog2(LOSS_TICKS + 1);

  logic [LOSS_W-1:0] cnt_q;

  assign expired_o = (cnt_q == LOSS_W'(LOSS_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart_i)             cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/lnk_state_fsm.sv
module lnk_state_fsm
  import lnk_pkg::*;
#(
  parameter int ENTRY_PULSES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic pulse_neg_i,
  input  logic carrier_i,
  input  logic expired_i,
  output logic pass_o,
  output logic enter_o,
  output logic drop_o
);
  localparam int RUN_W = $clog2(ENTRY_PULSES + 1);

  lnk_state_e       st_q;
  logic [RUN_W-1:0] run_q;
  logic             pol_q;
  logic [RUN_W-1:0] run_nx;
  logic             restart;

  assign restart = pulse_i || carrier_i;
  assign run_nx  = RUN_W'(lnk_run_step(int'(run_q), pulse_neg_i == pol_q, expired_i));
  assign drop_o  = (st_q == LNK_PASS) && expired_i && !restart;
  assign enter_o = (st_q == LNK_FAIL) &&
                   (carrier_i || (pulse_i && run_nx >= RUN_W'(ENTRY_PULSES)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LNK_FAIL;
      run_q <= '0;
      pol_q <= 1'b0;
    end else if (drop_o) begin
      st_q  <= LNK_FAIL;
      run_q <= '0;
    end else if (enter_o) begin
      st_q  <= LNK_PASS;
      run_q <= '0;
    end else if (st_q == LNK_FAIL && pulse_i) begin
      run_q <= run_nx;
      pol_q <= pulse_neg_i;
    end
  end

  assign pass_o = (st_q == LNK_PASS);

endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon #(
  parameter int PERIOD_TICKS = 16000,
  parameter int PULSE_CYCLES = 12,
  parameter int LOSS_TICKS   = 65000,
  parameter int ENTRY_PULSES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic tx_active_i,
  input  logic rx_carrier_i,
  input  logic rx_pulse_i,
  input  logic rx_pulse_neg_i,
  input  logic strap_off_i,
  output logic lp_req_o,
  output logic link_good_n_o,
  output logic path_en_o,
  output logic rcv_stat_o
);
  logic lp_fire;
  logic loss_expired;
  logic link_pass;
  logic link_enter;
  logic link_drop;

  lnk_pulse_gen #(.PERIOD_TICKS(PERIOD_TICKS), .PULSE_CYCLES(PULSE_CYCLES)) u_gen (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tx_active_i(tx_active_i),
    .fire_o(lp_fire), .lp_req_o(lp_req_o)
  );

  lnk_loss_timer #(.LOSS_TICKS(LOSS_TICKS)) u_loss (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .restart_i(rx_pulse_i || rx_carrier_i), .expired_o(loss_expired)
  );

  lnk_state_fsm #(.ENTRY_PULSES(ENTRY_PULSES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pulse_i(rx_pulse_i), .pulse_neg_i(rx_pulse_neg_i),
    .carrier_i(rx_carrier_i), .expired_i(loss_expired),
    .pass_o(link_pass), .enter_o(link_enter), .drop_o(link_drop)
  );

  assign path_en_o     = link_pass || strap_off_i;
  assign link_good_n_o = !path_en_o;
  assign rcv_stat_o    = rx_carrier_i && path_en_o;

endmodule

// File: rtl/lnk_integrity_chk.sv
module lnk_integrity_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_active_i,
  input logic rx_carrier_i,
  input logic rx_pulse_i,
  input logic strap_off_i,
  input logic lp_req_o,
  input logic link_good_n_o,
  input logic path_en_o,
  input logic rcv_stat_o,
  input logic fire,
  input logic expired
);
  p_fire_starts_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> lp_req_o);

  p_quiet_during_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active_i |=> !lp_req_o);

  p_reset_in_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (link_good_n_o || strap_off_i));

  p_loss_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !rx_pulse_i && !rx_carrier_i) |=> (link_good_n_o || strap_off_i));

  p_pass_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_good_n_o) && !strap_off_i) |-> $past(rx_pulse_i || rx_carrier_i || strap_off_i));

  p_carrier_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_carrier_i |=> !link_good_n_o);

  p_strap_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strap_off_i |-> (path_en_o && !link_good_n_o));

  p_rcv_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_stat_o |-> (rx_carrier_i && !link_good_n_o));

endmodule

bind lnk_integrity_mon lnk_integrity_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_active_i(tx_active_i), .rx_carrier_i(rx_carrier_i),
  .rx_pulse_i(rx_pulse_i), .strap_off_i(strap_off_i), .lp_req_o(lp_req_o),
  .link_good_n_o(link_good_n_o), .path_en_o(path_en_o), .rcv_stat_o(rcv_stat_o),
  .fire(lp_fire), .expired(loss_expired)
);

// File: tb/lnk_integrity_mon_bench.sv
module lnk_integrity_mon_bench;
  localparam int P = 20, W = 4, L = 30, E = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, tx = 1'b0, car = 1'b0, pul = 1'b0, neg = 1'b0, strap = 1'b0;
  logic lp_req, good_n, path_en, rcv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  lnk_integrity_mon #(.PERIOD_TICKS(P), .PULSE_CYCLES(W), .LOSS_TICKS(L), .ENTRY_PULSES(E))
  u_lnk_integrity_mon (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tx_active_i(tx), .rx_carrier_i(car),
    .rx_pulse_i(pul), .rx_pulse_neg_i(neg), .strap_off_i(strap),
    .lp_req_o(lp_req), .link_good_n_o(good_n), .path_en_o(path_en), .rcv_stat_o(rcv)
  );

  task automatic chk(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  // tick every second clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 2;
    tick <= (tdiv == 0);
  end

  // behavioural reference model
  int m_per = 0, m_wid = 0, m_loss = 0, m_run = 0;
  bit m_pass = 0, m_pol = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 0; m_wid = 0; m_loss = 0; m_run = 0; m_pass = 0; m_pol = 0;
    end else begin : step
      bit stale, restart;
      int nrun;
      stale   = (m_loss == L);
      restart = pul || car;
      if (tx) begin
        m_per = 0; m_wid = 0;
      end else begin
        if (m_wid > 0) m_wid--;
        if (tick) begin
          if (m_per == P - 1) begin m_per = 0; m_wid = W; end
          else m_per++;
        end
      end
      if (restart) m_loss = 0;
      else if (tick && !stale) m_loss++;
      if (m_pass) begin
        if (stale && !restart) begin m_pass = 0; m_run = 0; end
      end else if (car) begin
        m_pass = 1; m_run = 0;
      end else if (pul) begin
        nrun = (m_run == 0 || stale || neg != m_pol) ? 1 : m_run + 1;
        if (nrun >= E) begin m_pass = 1; m_run = 0; end
        else begin m_run = nrun; m_pol = neg; end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R1 lp_req_o vs model", lp_req, m_wid > 0);
      chk("R8 path_en_o vs model", path_en, m_pass || strap);
      chk("R8 link_good_n_o vs model", good_n, !(m_pass || strap));
      chk("R10 rcv_stat_o vs model", rcv, car && (m_pass || strap));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit negpol);
    @(negedge clk); pul = 1'b1; neg = negpol;
    @(negedge clk); pul = 1'b0;
    cyc(3);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    done = 1'b1;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int hi, lo, cnt;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 link_good_n_o after reset", good_n, 1'b1);
    chk("R3 path_en_o after reset", path_en, 1'b0);

    // R1: width and interval of the idle pulse
    cnt = 0;
    while (!lp_req && cnt < 200) begin @(negedge clk); cnt++; end
    hi = 0; while (lp_req && hi < 200) begin @(negedge clk); hi++; end
    lo = 0; while (!lp_req && lo < 200) begin @(negedge clk); lo++; end
    chk("R1 pulse width", hi == W, 1'b1);
    chk("R1 pulse interval", (hi + lo) == 2 * P, 1'b1);

    // R2: transmit activity suppresses pulses
    @(negedge clk); tx = 1'b1;
    cnt = 0;
    for (int i = 0; i < 120; i++) begin @(negedge clk); if (lp_req) cnt++; end
    chk("R2 no pulse while transmitting", cnt == 0, 1'b1);
    tx = 1'b0;

    // R5: positive run
    for (int i = 0; i < E - 1; i++) send(1'b0);
    chk("R5 still fail one pulse short", good_n, 1'b1);
    @(negedge clk); pul = 1'b1; neg = 1'b0;
    @(negedge clk); pul = 1'b0;
    chk("R5 pass on last pulse of run", good_n, 1'b0);

    // R4: kept alive, then starved
    for (int i = 0; i < 4; i++) begin send(1'b1); cyc(30); end
    chk("R4 pulses keep link in pass", good_n, 1'b0);
    cyc(80);
    chk("R4 fail after silence", good_n, 1'b1);

    // R6: polarity flip restarts the run, negative run enters pass
    for (int i = 0; i < 3; i++) send(1'b0);
    for (int i = 0; i < E - 1; i++) send(1'b1);
    chk("R6 flipped run still fail", good_n, 1'b1);
    send(1'b1);
    chk("R6 negative run reaches pass", good_n, 1'b0);
    cyc(80);
    chk("R4 fail after silence again", good_n, 1'b1);

    // R6: stale run after timeout
    for (int i = 0; i < 3; i++) send(1'b0);
    cyc(80);
    for (int i = 0; i < 2; i++) send(1'b0);
    chk("R6 stale run does not pass", good_n, 1'b1);
    for (int i = 0; i < 3; i++) send(1'b0);
    chk("R6 fresh run passes", good_n, 1'b0);
    cyc(80);

    // R7 and R10: carrier in fail
    chk("R7 fail before carrier", good_n, 1'b1);
    car = 1'b1;
    #1 chk("R10 rcv_stat_o suppressed in fail", rcv, 1'b0);
    cyc(1);
    chk("R7 pass after carrier", good_n, 1'b0);
    chk("R10 rcv_stat_o in pass", rcv, 1'b1);
    cyc(8);
    car = 1'b0;
    cyc(80);
    chk("R4 fail after carrier stops", good_n, 1'b1);

    // R9: strap forces enable, pulses continue
    strap = 1'b1;
    #1 chk("R9 path_en_o with strap", path_en, 1'b1);
    chk("R9 link_good_n_o with strap", good_n, 1'b0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (lp_req) cnt++; end
    chk("R9 pulses continue with strap", cnt > 0, 1'b1);
    strap = 1'b0;
    #1 chk("R8 fail visible after strap release", good_n, 1'b1);

    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule